// File: doc/BRIEF.md
# Two-Digit Decimal Window Counter

This block is a synchronous decimal counter made of two cascaded 4-bit decade stages. One stage holds the units digit and the other holds the tens digit. It does not count from 00. It steps through the window 05, 06, and so on up to 87, then returns to 05 and repeats for as long as counting stays enabled. The return to the start value uses the synchronous parallel load of both stages, so it takes effect on a clock edge.

A control module turns the reset and count-enable inputs, together with two status flags from the datapath, into a small set of strobes. The strobes are load-start, units-increment and tens-increment. The datapath holds the two decade stages and computes the flags "units at 9" and "state at end". The outputs are the two digits, a packed 8-bit word, and a terminal-count flag. The start and end values are parameters given as decimal numbers, and the digit values are derived from them.

Top module: `bcd_window_counter`

## Requirements
- R1: When `rst` is high at a clock edge, the state becomes 05 (tens 0, units 5) on that edge, whatever the value of `en`.
- R2: When `rst` is low and `en` is low at a clock edge, both digits keep their values.
- R3: Each digit stays in 0..9. The units digit goes from 9 to 0 when it advances.
- R4: The tens digit advances by one only on an enabled edge where the units digit is 9 and the state is not 87. On every other enabled edge, tens holds.
- R5: An enabled edge in state 87 loads 05. This takes precedence over the normal carry.
- R6: `packedWord[7:4]` is the tens digit and `packedWord[3:0]` is the units digit, each in plain BCD. Bit 7 is the MSB of tens and bit 0 is the LSB of units.
- R7: `termCount` is high exactly while the state is 87.
- R8: Starting from 05 with `en` held high, the counter passes through exactly 83 distinct states, each one greater than the previous, and is back at 05 after 83 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to the start value, active high |
| en | input | 1 | Count enable |
| unitsDigit | output | 4 | Units digit in BCD |
| tensDigit | output | 4 | Tens digit in BCD |
| packedWord | output | 8 | Tens digit in bits 7:4, units digit in bits 3:0 |
| termCount | output | 1 | High while the state equals the end value (87) |

## Verification
The bench builds the block with its default window of 05 to 87. This window includes a non-zero start and an end whose units digit is not 9. As a result, the forced wrap at 87 is separate from the ordinary units-to-tens carry, and the walk passes through every tens rollover from 09 to 79. A full walk of 83 edges checks every state, together with reset and hold at both the middle and the end of the window.

// File: rtl/bcd_window_pkg.sv
package bcd_window_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic loadStart;
    logic unitsInc;
    logic tensInc;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage #(
  parameter int W = 4,
  parameter int MAX_DIGIT = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX_V = W'(MAX_DIGIT);

  always_ff @(posedge clk) begin
    if (load)
      q <= loadVal;
    else if (inc)
      q <= (q == MAX_V) ? '0 : q + 1'b1;
  end

  // R3: a stage never leaves the decade range
  p_valid_bcd_r3: assert property (@(posedge clk) disable iff (rst) q <= MAX_V)
    else $error("stage out of range");

  // R3: 9 rolls to 0 on increment
  p_decade_roll_r3: assert property (@(posedge clk) disable iff (rst)
      (inc && !load && q == MAX_V) |=> (q == '0))
    else $error("stage roll wrong");
endmodule

// File: rtl/bcd_window_ctrl.sv
module bcd_window_ctrl
  import bcd_window_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         unitsNine,
  input  logic         atEnd,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.loadStart = rst || (en && atEnd);
    strobes.unitsInc  = en && !atEnd && !rst;
    strobes.tensInc   = en && !atEnd && !rst && unitsNine;
  end

  // R4: tens strobe only alongside a units strobe
  p_tens_needs_units_r4: assert property (@(posedge clk) disable iff (rst)
      strobes.tensInc |-> strobes.unitsInc)
    else $error("tens strobe without units strobe");
endmodule

// File: rtl/bcd_window_datapath.sv
module bcd_window_datapath
  import bcd_window_pkg::*;
#(
  parameter int START_VAL = 5,
  parameter int END_VAL = 87
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  ctrlStrobes_t       strobes,
  output logic [DIGIT_W-1:0] units,
  output logic [DIGIT_W-1:0] tens,
  output logic               unitsNine,
  output logic               atEnd
);
  localparam logic [DIGIT_W-1:0] START_U = DIGIT_W'(START_VAL % 10);
  localparam logic [DIGIT_W-1:0] START_T = DIGIT_W'(START_VAL / 10);
  localparam logic [DIGIT_W-1:0] END_U   = DIGIT_W'(END_VAL % 10);
  localparam logic [DIGIT_W-1:0] END_T   = DIGIT_W'(END_VAL / 10);
  localparam int NSTAGE = 2;

  logic [DIGIT_W-1:0] stageQ   [NSTAGE];
  logic [DIGIT_W-1:0] stageLd  [NSTAGE];
  logic               stageInc [NSTAGE];

  assign stageLd[0]  = START_U;
  assign stageLd[1]  = START_T;
  assign stageInc[0] = strobes.unitsInc;
  assign stageInc[1] = strobes.tensInc;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    bcd_decade_stage #(.W(DIGIT_W), .MAX_DIGIT(9)) u_stage (
      .clk(clk), .rst(rst), .load(strobes.loadStart),
      .loadVal(stageLd[g]), .inc(stageInc[g]), .q(stageQ[g])
    );
  end

  assign units     = stageQ[0];
  assign tens      = stageQ[1];
  assign unitsNine = (units == DIGIT_W'(9));
  assign atEnd     = (units == END_U) && (tens == END_T);

  // R1: reset loads the start value regardless of enable
  p_reset_start_r1: assert property (@(posedge clk)
      rst |=> (tens == START_T && units == START_U))
    else $error("reset did not load start");

  // R2: disabled cycles hold both digits
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(units) && $stable(tens)))
    else $error("digits moved while disabled");

  // R4: tens holds unless units was 9
  p_tens_step_r4: assert property (@(posedge clk) disable iff (rst)
      (en && !unitsNine && !atEnd) |=> $stable(tens))
    else $error("tens moved without carry");

  // R5: end value wraps to start
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (en && atEnd) |=> (tens == START_T && units == START_U))
    else $error("wrap missed");
endmodule

// File: rtl/bcd_window_counter.sv
module bcd_window_counter
  import bcd_window_pkg::*;
#(
  parameter int START_VAL = 5,
  parameter int END_VAL = 87
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  output logic [DIGIT_W-1:0]   unitsDigit,
  output logic [DIGIT_W-1:0]   tensDigit,
  output logic [2*DIGIT_W-1:0] packedWord,
  output logic                 termCount
);
  ctrlStrobes_t strobes;
  logic unitsNine;
  logic atEnd;

  bcd_window_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .unitsNine(unitsNine), .atEnd(atEnd), .strobes(strobes)
  );

  bcd_window_datapath #(.START_VAL(START_VAL), .END_VAL(END_VAL)) u_dp (
    .clk(clk), .rst(rst), .en(en), .strobes(strobes),
    .units(unitsDigit), .tens(tensDigit),
    .unitsNine(unitsNine), .atEnd(atEnd)
  );

  // R6: tens in the upper nibble, units in the lower nibble
  assign packedWord = {tensDigit, unitsDigit};
  // R7: terminal flag
  assign termCount  = atEnd;
endmodule

// File: tb/tb_bcd_window_counter.sv
module tb_bcd_window_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [3:0] unitsDigit, tensDigit;
  logic [7:0] packedWord;
  logic termCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_window_counter dut (
    .clk(clk), .rst(rst), .en(en),
    .unitsDigit(unitsDigit), .tensDigit(tensDigit),
    .packedWord(packedWord), .termCount(termCount)
  );

  // {rst, en, expTens[3:0], expUnits[3:0], expTerm}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0, 4'd5, 1'b0},
    {1'b0, 1'b1, 4'd0, 4'd6, 1'b0},
    {1'b0, 1'b1, 4'd0, 4'd7, 1'b0},
    {1'b0, 1'b0, 4'd0, 4'd7, 1'b0},
    {1'b0, 1'b1, 4'd0, 4'd8, 1'b0},
    {1'b0, 1'b1, 4'd0, 4'd9, 1'b0},
    {1'b0, 1'b0, 4'd0, 4'd9, 1'b0},
    {1'b0, 1'b1, 4'd1, 4'd0, 1'b0},
    {1'b0, 1'b1, 4'd1, 4'd1, 1'b0},
    {1'b1, 1'b1, 4'd0, 4'd5, 1'b0},
    {1'b0, 1'b0, 4'd0, 4'd5, 1'b0},
    {1'b0, 1'b1, 4'd0, 4'd6, 1'b0}
  };
  localparam int VREQ [NV] = '{1, 3, 3, 2, 3, 3, 2, 4, 3, 1, 2, 3};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int curVal();
    return int'(tensDigit) * 10 + int'(unitsDigit);
  endfunction

  task automatic step(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen [100];
    int distinct;
    int prev;

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9]);
      chk($sformatf("R%0d tens vec%0d", VREQ[i], i), int'(tensDigit), int'(VEC[i][8:5]));
      chk($sformatf("R%0d units vec%0d", VREQ[i], i), int'(unitsDigit), int'(VEC[i][4:1]));
      chk($sformatf("R7 term vec%0d", i), int'(termCount), int'(VEC[i][0]));
    end

    // R6: packing
    chk("R6 packed", int'(packedWord), 8'h06);

    // R8: full walk from the start value
    step(1'b1, 1'b0);
    chk("R1 reset", curVal(), 5);
    foreach (seen[k]) seen[k] = 1'b0;
    distinct = 0;
    prev = curVal();
    for (int s = 0; s < 83; s++) begin
      if (!seen[prev]) begin
        seen[prev] = 1'b1;
        distinct++;
      end
      chk("R7 term walk", int'(termCount), (prev == 87) ? 1 : 0);
      step(1'b0, 1'b1);
      chk("R3 units range", int'(unitsDigit <= 4'd9), 1);
      chk("R3 tens range", int'(tensDigit <= 4'd9), 1);
      chk("R6 packed walk", int'(packedWord),
          int'({tensDigit, unitsDigit}));
      chk((prev == 87) ? "R5 wrap" : "R4 step", curVal(),
          (prev == 87) ? 5 : prev + 1);
      prev = curVal();
    end
    chk("R8 distinct", distinct, 83);
    chk("R8 back to start", curVal(), 5);

    // R5/R2/R7: hold at end, then wrap
    step(1'b1, 1'b0);
    for (int s = 0; s < 82; s++) step(1'b0, 1'b1);
    chk("R7 at end", int'(termCount), 1);
    chk("R7 value at end", curVal(), 87);
    step(1'b0, 1'b0);
    chk("R2 hold at end", curVal(), 87);
    chk("R7 still end", int'(termCount), 1);
    step(1'b0, 1'b1);
    chk("R5 wrap value", int'(packedWord), 8'h05);
    chk("R7 cleared", int'(termCount), 0);

    // R1: reset at end beats enable
    for (int s = 0; s < 82; s++) step(1'b0, 1'b1);
    chk("R5 reach end again", curVal(), 87);
    step(1'b1, 1'b1);
    chk("R1 reset at end", curVal(), 5);

    // R4: carry at 19 vs no carry at 18
    for (int s = 0; s < 13; s++) step(1'b0, 1'b1);
    chk("R4 at 18", curVal(), 18);
    step(1'b0, 1'b1);
    chk("R4 tens holds", int'(tensDigit), 1);
    step(1'b0, 1'b1);
    chk("R4 tens carry", int'(tensDigit), 2);
    chk("R3 units roll", int'(unitsDigit), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule